// File: doc/BRIEF.md
# Secondary-Core Boot Release Table

This block is a bank of boot-release slots, one per processor core, reached through a simple register port. Each slot is 32 bytes and stores its fields most-significant byte first. Boot software parks a secondary core by leaving bit 0 of its slot's 64-bit start address set. It releases the core by writing the slot so that this bit ends up clear. The block then presents, for one cycle, the core's index and the launch data: the start offset inside a 64 MiB window, the window base, the window size and the argument.

A small two-state machine produces the launch pulse. In REL_IDLE nothing is launched. A write that is accepted and leaves the address with bit 0 clear moves it to REL_FIRE (transition IDLE_TO_FIRE). In REL_FIRE the pulse and the launch buses are driven for that cycle. A further qualifying write in that same cycle keeps it in REL_FIRE with the new core's data (FIRE_TO_FIRE). Otherwise it returns to REL_IDLE (FIRE_TO_IDLE). The remaining transition, IDLE_TO_IDLE, holds in REL_IDLE. Slot 0 belongs to the primary core and cannot be written. A slot whose core is marked absent on `core_present` cannot be written either.

Top module: `spin_release_ctrl`

## Requirements
- R1: After reset, slot i holds start address 1, argument i, processor ID i, and zero in both reserved fields. No launch pulse is active and `bus_rvalid` is low.
- R2: Within a slot, bytes 0-7 are the start address, 8-15 the argument, 16-19 a reserved word, 20-23 the processor ID and 24-31 a reserved doubleword. Byte n of a field is its most significant. Read data is right-aligned in `bus_rdata`, with the lowest-addressed byte most significant.
- R3: A read (size code 0 = byte, 1 = halfword, 2 = word) returns data with `bus_rvalid` high in the cycle after the request. Size code 3 instead returns `bus_rerr` high with `bus_rdata` zero.
- R4: A write of size 0, 1 or 2 updates only the addressed bytes. Address bits below the access size are ignored. A write with size code 3 changes nothing.
- R5: An accepted write that leaves bit 0 of the slot's start address clear raises `rel_pulse` for exactly one cycle, in the cycle after the write. Only the bit of that core is set.
- R6: Writes anywhere in slot 0 are discarded and never launch.
- R7: Writes to a slot whose `core_present` bit is 0 are discarded and never launch.
- R8: With the pulse, `rel_core` carries the slot index and `rel_arg` the argument. `rel_offset` is the start address modulo 2^26. `rel_base` is the address with its low 26 bits cleared. `rel_span` is 2^26. All four launch buses are zero when no pulse is active.
- R9: On launch, the slot's processor ID field becomes `core_hwid` of that core.
- R10: Every accepted write to a slot whose address bit 0 is clear after the write launches again, whichever field it touches. Writes that leave bit 0 set do not launch.
- R11: Qualifying writes in consecutive cycles give pulses in consecutive cycles, each carrying its own core's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address: slot index in bits 9:5, byte offset in bits 4:0 |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | 32 | Read data, right-aligned |
| bus_rerr | output | 1 | Read with invalid size |
| core_present | input | 32 | One bit per slot: core exists |
| core_hwid | input | 32 x 32 | Hardware ID per core |
| rel_pulse | output | 32 | One-hot launch pulse |
| rel_core | output | 5 | Launched core index |
| rel_offset | output | 64 | Start offset inside the window |
| rel_arg | output | 64 | Launch argument |
| rel_base | output | 64 | Window base |
| rel_span | output | 64 | Window size |

## Verification
The launch rule is tried with several kinds of write. Address writes that keep bit 0 set must stay silent. Address writes that clear it must fire. Argument and reserved-field writes made after bit 0 is already clear must fire again. This shows that the rule looks at the merged slot contents, not at which field was written. The same write is also sent to slot 0 and to an absent slot, which separates the two discard paths from the merge logic. Byte, halfword, misaligned-halfword and invalid-size writes on one field, each followed by a read-back, show that only the addressed bytes change. Two launches in consecutive cycles show that the second does not overwrite the first.

// File: rtl/spin_pkg.sv
package spin_pkg;

    localparam int SLOT_BYTES = 32;
    localparam int SLOT_W     = SLOT_BYTES * 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic {
        REL_IDLE = 1'b0,
        REL_FIRE = 1'b1
    } rel_state_e;

    // Slot fields, highest bits first: start address, argument,
    // reserved word, processor ID, reserved doubleword.
    function automatic logic [SLOT_W-1:0] slot_reset_value(input int idx);
        return {64'd1, 64'(idx), 32'd0, 32'(idx), 64'd0};
    endfunction

endpackage

// File: rtl/spin_lane_map.sv
module spin_lane_map
    import spin_pkg::*;
(
    input  logic [4:0]            offset,
    input  acc_size_e             size,
    input  logic [31:0]           wdata,
    input  logic [SLOT_W-1:0]     slot_row,
    output logic [SLOT_BYTES-1:0] byte_mask,
    output logic [SLOT_W-1:0]     byte_data,
    output logic [31:0]           rdata
);

    always_comb begin
        int first;
        int count;
        unique case (size)
            SZ_BYTE: begin first = int'(offset);               count = 1; end
            SZ_HALF: begin first = int'({offset[4:1], 1'b0});  count = 2; end
            default: begin first = int'({offset[4:2], 2'b00}); count = 4; end
        endcase

        byte_mask = '0;
        byte_data = '0;
        for (int k = 0; k < SLOT_BYTES; k++) begin
            if (k >= first && k < first + count) begin
                byte_mask[k] = 1'b1;
                byte_data[SLOT_W-1-8*k -: 8] = wdata[8*(count-1-(k-first)) +: 8];
            end
        end

        rdata = '0;
        for (int j = 0; j < 4; j++) begin
            if (j < count) begin
                rdata[8*(count-1-j) +: 8] = slot_row[SLOT_W-1-8*(first+j) -: 8];
            end
        end
    end

endmodule

// File: rtl/spin_slot_store.sv
module spin_slot_store
    import spin_pkg::*;
#(
    parameter int N_SLOTS = 32,
    localparam int IDX_W  = $clog2(N_SLOTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [SLOT_W-1:0]             wr_row,
    output logic [N_SLOTS-1:0][SLOT_W-1:0] slots
);

    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slots[i] <= slot_reset_value(i);
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                slots[i] <= wr_row;
            end
        end
    end

    // R6: the primary core's slot never changes after reset
    a_r6_slot0_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(slots[0]));

endmodule

// File: rtl/spin_release_fsm.sv
module spin_release_fsm
    import spin_pkg::*;
#(
    parameter int N_SLOTS  = 32,
    parameter int WIN_LOG2 = 26,
    localparam int IDX_W   = $clog2(N_SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire_req,
    input  logic [IDX_W-1:0]   fire_idx,
    input  logic [63:0]        fire_addr,
    input  logic [63:0]        fire_arg,
    output logic [N_SLOTS-1:0] rel_pulse,
    output logic [IDX_W-1:0]   rel_core,
    output logic [63:0]        rel_offset,
    output logic [63:0]        rel_arg,
    output logic [63:0]        rel_base,
    output logic [63:0]        rel_span
);

    localparam logic [63:0] WIN_SIZE = 64'd1 << WIN_LOG2;
    localparam logic [63:0] WIN_MASK = WIN_SIZE - 64'd1;

    rel_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic [63:0]      addr_q;
    logic [63:0]      arg_q;

    always_comb begin
        unique case (state_q)
            REL_IDLE: state_d = fire_req ? REL_FIRE : REL_IDLE;
            REL_FIRE: state_d = fire_req ? REL_FIRE : REL_IDLE;
            default:  state_d = REL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            addr_q <= '0;
            arg_q  <= '0;
        end else if (fire_req) begin
            idx_q  <= fire_idx;
            addr_q <= fire_addr;
            arg_q  <= fire_arg;
        end
    end

    always_comb begin
        rel_pulse  = '0;
        rel_core   = '0;
        rel_offset = '0;
        rel_arg    = '0;
        rel_base   = '0;
        rel_span   = '0;
        unique case (state_q)
            REL_FIRE: begin
                rel_pulse[idx_q] = 1'b1;
                rel_core         = idx_q;
                rel_offset       = addr_q & WIN_MASK;
                rel_arg          = arg_q;
                rel_base         = addr_q & ~WIN_MASK;
                rel_span         = WIN_SIZE;
            end
            default: ;
        endcase
    end

    // R5: at most one core launched per cycle
    a_r5_pulse_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rel_pulse));

    // R8: offset and base never share a bit, and a launched offset has bit 0 clear
    a_r8_split_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_offset & rel_base) == 64'd0);
    a_r10_bit0_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|rel_pulse) |-> (rel_offset[0] == 1'b0));

endmodule

// File: rtl/spin_read_port.sv
module spin_read_port (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_req,
    input  logic        rd_bad,
    input  logic [31:0] rd_word,
    output logic        rvalid,
    output logic [31:0] rdata,
    output logic        rerr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
            rerr   <= 1'b0;
        end else begin
            rvalid <= rd_req;
            rerr   <= rd_req && rd_bad;
            rdata  <= (rd_req && !rd_bad) ? rd_word : 32'd0;
        end
    end

    // R3: an error response is a valid response with zero data, caused by a bad-size read
    a_r3_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        rerr |-> (rvalid && rdata == 32'd0));
    a_r3_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rerr |-> $past(rd_req && rd_bad));

endmodule

// File: rtl/spin_release_ctrl.sv
module spin_release_ctrl
    import spin_pkg::*;
#(
    parameter int N_SLOTS  = 32,
    parameter int WIN_LOG2 = 26,
    localparam int IDX_W   = $clog2(N_SLOTS),
    localparam int ADDR_W  = IDX_W + $clog2(SLOT_BYTES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_req,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [1:0]                bus_size,
    input  logic [31:0]               bus_wdata,
    output logic                      bus_rvalid,
    output logic [31:0]               bus_rdata,
    output logic                      bus_rerr,
    input  logic [N_SLOTS-1:0]        core_present,
    input  logic [N_SLOTS-1:0][31:0]  core_hwid,
    output logic [N_SLOTS-1:0]        rel_pulse,
    output logic [IDX_W-1:0]          rel_core,
    output logic [63:0]               rel_offset,
    output logic [63:0]               rel_arg,
    output logic [63:0]               rel_base,
    output logic [63:0]               rel_span
);

    localparam int ADDR_HI = SLOT_W - 1;
    localparam int ADDR_LO = SLOT_W - 64;
    localparam int ARG_LO  = SLOT_W - 128;
    localparam int PID_HI  = SLOT_W - 161;
    localparam int PID_LO  = SLOT_W - 192;

    logic [N_SLOTS-1:0][SLOT_W-1:0] slots;
    logic [IDX_W-1:0]               idx;
    logic [4:0]                     offset;
    acc_size_e                      size;
    logic [SLOT_W-1:0]              cur_row;
    logic [SLOT_BYTES-1:0]          byte_mask;
    logic [SLOT_W-1:0]              byte_data;
    logic [SLOT_W-1:0]              bit_mask;
    logic [SLOT_W-1:0]              merged;
    logic [SLOT_W-1:0]              new_row;
    logic [31:0]                    lane_word;
    logic                           wr_ok;
    logic                           fire_now;

    assign idx     = bus_addr[ADDR_W-1:5];
    assign offset  = bus_addr[4:0];
    assign size    = acc_size_e'(bus_size);
    assign cur_row = slots[idx];

    spin_lane_map u_lane (
        .offset    (offset),
        .size      (size),
        .wdata     (bus_wdata),
        .slot_row  (cur_row),
        .byte_mask (byte_mask),
        .byte_data (byte_data),
        .rdata     (lane_word)
    );

    always_comb begin
        for (int k = 0; k < SLOT_BYTES; k++) begin
            bit_mask[SLOT_W-1-8*k -: 8] = {8{byte_mask[k]}};
        end
    end

    assign merged   = (cur_row & ~bit_mask) | (byte_data & bit_mask);
    assign wr_ok    = bus_req && bus_we && (size != SZ_BAD)
                      && (idx != '0) && core_present[idx];
    assign fire_now = wr_ok && !merged[ADDR_LO];

    always_comb begin
        new_row = merged;
        if (fire_now) begin
            new_row[PID_HI:PID_LO] = core_hwid[idx];
        end
    end

    spin_slot_store #(.N_SLOTS(N_SLOTS)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_ok),
        .wr_idx (idx),
        .wr_row (new_row),
        .slots  (slots)
    );

    spin_release_fsm #(.N_SLOTS(N_SLOTS), .WIN_LOG2(WIN_LOG2)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_req   (fire_now),
        .fire_idx   (idx),
        .fire_addr  (merged[ADDR_HI:ADDR_LO]),
        .fire_arg   (merged[ADDR_LO-1:ARG_LO]),
        .rel_pulse  (rel_pulse),
        .rel_core   (rel_core),
        .rel_offset (rel_offset),
        .rel_arg    (rel_arg),
        .rel_base   (rel_base),
        .rel_span   (rel_span)
    );

    spin_read_port u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_req  (bus_req && !bus_we),
        .rd_bad  (size == SZ_BAD),
        .rd_word (lane_word),
        .rvalid  (bus_rvalid),
        .rdata   (bus_rdata),
        .rerr    (bus_rerr)
    );

    // R5: every launch pulse is preceded by a write request
    a_r5_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|rel_pulse) |-> $past(bus_req && bus_we));

    // R7: no absent core is ever launched
    a_r7_absent_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_pulse & ~$past(core_present)) == '0);

    // R6: the primary core is never launched
    a_r6_primary_silent: assert property (@(posedge clk) disable iff (!rst_n)
        rel_pulse[0] == 1'b0);

endmodule

// File: tb/spin_release_ctrl_tb.sv
module spin_release_ctrl_tb;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0;
    logic              bus_we = 1'b0;
    logic [9:0]        bus_addr = '0;
    logic [1:0]        bus_size = '0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_rvalid;
    logic [31:0]       bus_rdata;
    logic              bus_rerr;
    logic [31:0]       core_present;
    logic [31:0][31:0] core_hwid;
    logic [31:0]       rel_pulse;
    logic [4:0]        rel_core;
    logic [63:0]       rel_offset, rel_arg, rel_base, rel_span;

    int total = 0;
    int bad = 0;
    logic [31:0] cap_pulse;
    logic [31:0] cap_rdata;
    logic        cap_rerr;

    always #5 clk = ~clk;

    spin_release_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_rerr(bus_rerr),
        .core_present(core_present), .core_hwid(core_hwid),
        .rel_pulse(rel_pulse), .rel_core(rel_core), .rel_offset(rel_offset),
        .rel_arg(rel_arg), .rel_base(rel_base), .rel_span(rel_span)
    );

    typedef struct packed {
        logic        we;
        logic [9:0]  addr;
        logic [1:0]  size;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 26;
    // size: 0 byte, 1 half, 2 word, 3 bad; write exp = 1 when a launch is expected
    localparam vec_t VECS [NV] = '{
        '{1'b0, 10'h060, 2'd2, 32'h0,        32'h0,        4'd1},  // R1 addr hi
        '{1'b0, 10'h064, 2'd2, 32'h0,        32'h1,        4'd1},  // R1 addr lo
        '{1'b0, 10'h06C, 2'd2, 32'h0,        32'h3,        4'd1},  // R1 arg
        '{1'b0, 10'h074, 2'd2, 32'h0,        32'h3,        4'd1},  // R1 pid
        '{1'b0, 10'h077, 2'd0, 32'h0,        32'h3,        4'd2},  // R2 LSB of pid
        '{1'b0, 10'h074, 2'd0, 32'h0,        32'h0,        4'd2},  // R2 MSB of pid
        '{1'b0, 10'h076, 2'd1, 32'h0,        32'h3,        4'd2},  // R2 half
        '{1'b0, 10'h066, 2'd1, 32'h0,        32'h1,        4'd2},  // R2 half
        '{1'b1, 10'h048, 2'd2, 32'hAABBCCDD, 32'h0,        4'd10}, // R10 bit0 still set
        '{1'b0, 10'h048, 2'd2, 32'h0,        32'hAABBCCDD, 4'd4},  // R4
        '{1'b1, 10'h049, 2'd0, 32'h00000011, 32'h0,        4'd4},  // R4 byte
        '{1'b0, 10'h048, 2'd2, 32'h0,        32'hAA11CCDD, 4'd4},  // R4
        '{1'b1, 10'h04E, 2'd1, 32'h00001234, 32'h0,        4'd4},  // R4 half
        '{1'b0, 10'h04C, 2'd2, 32'h0,        32'h00001234, 4'd4},  // R4
        '{1'b1, 10'h04D, 2'd1, 32'h00005678, 32'h0,        4'd4},  // R4 low bit ignored
        '{1'b0, 10'h04C, 2'd2, 32'h0,        32'h56781234, 4'd4},  // R4
        '{1'b1, 10'h04B, 2'd3, 32'hFFFFFFFF, 32'h0,        4'd4},  // R4 bad size
        '{1'b0, 10'h048, 2'd2, 32'h0,        32'hAA11CCDD, 4'd4},  // R4 unchanged
        '{1'b1, 10'h004, 2'd2, 32'h0,        32'h0,        4'd6},  // R6 slot 0
        '{1'b0, 10'h004, 2'd2, 32'h0,        32'h1,        4'd6},  // R6 unchanged
        '{1'b1, 10'h0A4, 2'd2, 32'h0,        32'h0,        4'd7},  // R7 absent slot 5
        '{1'b0, 10'h0A4, 2'd2, 32'h0,        32'h1,        4'd7},  // R7 unchanged
        '{1'b1, 10'h044, 2'd2, 32'h0C001000, 32'h1,        4'd5},  // R5 launch slot 2
        '{1'b0, 10'h054, 2'd2, 32'h0,        32'h102,      4'd9},  // R9 pid = hwid
        '{1'b1, 10'h050, 2'd2, 32'hDEAD0000, 32'h1,        4'd10}, // R10 reserved write
        '{1'b0, 10'h050, 2'd2, 32'h0,        32'hDEAD0000, 4'd4}   // R4
    };

    task automatic chk(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [9:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
        @(negedge clk);
        cap_pulse = rel_pulse;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic do_read(input logic [9:0] a, input logic [1:0] s);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = s;
        @(negedge clk);
        cap_rdata = bus_rdata;
        cap_rerr  = bus_rerr;
        chk(bus_rvalid == 1'b1, "R3 rvalid", 64'(bus_rvalid), 64'd1);
        bus_req = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) core_hwid[i] = 32'h100 + 32'(i);
        core_present = 32'hFFFF_FFDF;  // slot 5 absent
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rel_pulse == '0, "R1 pulse", 64'(rel_pulse), 64'd0);
        chk(bus_rvalid == 1'b0, "R1 rvalid", 64'(bus_rvalid), 64'd0);
        chk(rel_offset == '0 && rel_span == '0, "R8 idle buses", rel_span, 64'd0);

        for (int v = 0; v < NV; v++) begin
            if (VECS[v].we) begin
                do_write(VECS[v].addr, VECS[v].size, VECS[v].data);
                chk((|cap_pulse) == VECS[v].exp[0], $sformatf("R%0d vec%0d launch", VECS[v].req, v),
                    64'(cap_pulse), 64'(VECS[v].exp[0]));
            end else begin
                do_read(VECS[v].addr, VECS[v].size);
                chk(cap_rdata == VECS[v].exp && !cap_rerr, $sformatf("R%0d vec%0d read", VECS[v].req, v),
                    64'(cap_rdata), 64'(VECS[v].exp));
            end
        end

        // R10: slot 7 writes keeping bit 0 set stay silent
        do_write(10'h0E0, 2'd2, 32'h0000_0001);
        chk(cap_pulse == '0, "R10 addr hi", 64'(cap_pulse), 64'd0);
        do_write(10'h0E8, 2'd2, 32'h0);
        chk(cap_pulse == '0, "R10 arg hi", 64'(cap_pulse), 64'd0);
        do_write(10'h0EC, 2'd2, 32'hCAFE_0000);
        chk(cap_pulse == '0, "R10 arg lo", 64'(cap_pulse), 64'd0);

        // R8: launch slot 7 and check the split
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 10'h0E4; bus_size = 2'd2; bus_wdata = 32'h0A5B_CDE6;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        chk(rel_pulse == 32'h80, "R5 pulse slot7", 64'(rel_pulse), 64'h80);
        chk(rel_core == 5'd7, "R8 core", 64'(rel_core), 64'd7);
        chk(rel_offset == 64'h025B_CDE6, "R8 offset", rel_offset, 64'h025B_CDE6);
        chk(rel_base == 64'h0000_0001_0800_0000, "R8 base", rel_base, 64'h0000_0001_0800_0000);
        chk(rel_arg == 64'h0000_0000_CAFE_0000, "R8 arg", rel_arg, 64'h0000_0000_CAFE_0000);
        chk(rel_span == 64'h0400_0000, "R8 span", rel_span, 64'h0400_0000);
        @(negedge clk);
        chk(rel_pulse == '0, "R5 single cycle", 64'(rel_pulse), 64'd0);
        chk(rel_arg == '0, "R8 zero after pulse", rel_arg, 64'd0);

        // R9: processor ID replaced by hardware ID
        do_read(10'h0F4, 2'd2);
        chk(cap_rdata == 32'h107, "R9 pid slot7", 64'(cap_rdata), 64'h107);

        // R10: argument byte write relaunches with new argument
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 10'h0EF; bus_size = 2'd0; bus_wdata = 32'h55;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        chk(rel_pulse == 32'h80, "R10 relaunch", 64'(rel_pulse), 64'h80);
        chk(rel_arg == 64'h0000_0000_CAFE_0055, "R10 new arg", rel_arg, 64'h0000_0000_CAFE_0055);

        // R11: back-to-back launches of slots 8 and 9
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 10'h104; bus_size = 2'd2; bus_wdata = 32'h0000_2000;
        @(negedge clk);
        chk(rel_pulse == 32'h100 && rel_offset == 64'h2000 && rel_base == 64'd0,
            "R11 first", 64'(rel_pulse), 64'h100);
        bus_addr = 10'h124; bus_wdata = 32'h0400_3000;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        chk(rel_pulse == 32'h200 && rel_core == 5'd9, "R11 second", 64'(rel_pulse), 64'h200);
        chk(rel_offset == 64'h3000 && rel_base == 64'h0400_0000, "R11 second split", rel_base, 64'h0400_0000);
        @(negedge clk);
        chk(rel_pulse == '0, "R11 end", 64'(rel_pulse), 64'd0);

        // R3: bad-size read
        do_read(10'h064, 2'd3);
        chk(cap_rerr == 1'b1 && cap_rdata == '0, "R3 bad size", {cap_rdata, 31'd0, cap_rerr}, 64'd1);
        do_read(10'h064, 2'd2);
        chk(cap_rerr == 1'b0, "R3 good size no err", 64'(cap_rerr), 64'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule